// File: doc/BRIEF.md
# Burst Readout Channel Latch

This block sits on the host side of a four-channel simultaneous-sampling converter. The converter signals the end of a conversion set by pulling an active-low interrupt line low. The block detects that falling edge and then reads the four results back one by one. It drops chip-select for the whole burst and drives four read strobes in turn. The converter places the result of read k on the 16-bit bus while that strobe is low.

Only one of the four reads is kept. A 2-bit binary channel select, sampled when the burst begins, names the read to capture. On the last low cycle of that read the block raises a one-cycle latch strobe. The bus word is stored on the closing clock edge of that cycle, and a one-cycle valid pulse then marks the new held word. The word is passed through bit for bit, so a two's complement result keeps its sign bits. An interrupt edge that arrives while a burst is still running does not start a new burst. Instead it sets a sticky overrun flag.

Top module: `burst_readout_latch`

## Requirements
- R1: After reset, cs_n and rd_n are 1, latch_stb, held_valid and overrun are 0, and held_data is 0.
- R2: A burst starts only on a high-to-low change of int_n after synchronisation. cs_n goes low at the third rising clock edge that follows the first edge sampling int_n low.
- R3: Each burst holds exactly four rd_n low pulses, which are reads 0, 1, 2 and 3 in that order.
- R4: Each rd_n low pulse lasts PULSE_LOW cycles (default 2). Each high interval inside the burst lasts PULSE_GAP cycles (default 2). This covers the interval before the first read, the intervals between reads, and the interval after the last read before cs_n rises.
- R5: cs_n stays low from the start of the burst until after the fourth pulse, and rd_n is never low while cs_n is high.
- R6: latch_stb is high for exactly one cycle per burst. That cycle is the last low cycle of the read whose index equals chan_sel in binary (00 selects read 0, 11 selects read 3).
- R7: held_data takes data_in at the clock edge that ends the latch_stb cycle, bit for bit, so a negative word such as 16'hE00F keeps its sign bits. held_valid is 1 for exactly the following cycle, and held_data does not change in any other cycle.
- R8: chan_sel is sampled when the burst starts, and a change of chan_sel during the burst has no effect on which read is captured.
- R9: A falling int_n during a burst is ignored: the burst keeps its four reads and no second burst follows. The edge sets overrun, which stays 1 until reset.
- R10: int_n held low after a burst ends starts no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| chan_sel | input | 2 | Binary index of the read to capture |
| data_in | input | 16 | Converter data bus |
| cs_n | output | 1 | Chip-select to converter, active low |
| rd_n | output | 1 | Read strobe to converter, active low |
| latch_stb | output | 1 | One-cycle capture strobe |
| held_data | output | 16 | Captured result word |
| held_valid | output | 1 | One-cycle pulse after each capture |
| overrun | output | 1 | Sticky flag: interrupt edge seen during a burst |

## Verification
Capture of the selected read and detection of an overrunning interrupt edge can fall in the same cycle. The bench provokes this by raising int_n once chip-select falls and dropping it again one cycle later. With channel 0 selected, the synchronised falling edge then lands exactly in the latch-strobe cycle of read 0. It is judged correct when the read 0 word is still captured with a single valid pulse, the burst keeps four correctly timed reads, overrun is set, and no second burst follows.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;
endpackage

// File: rtl/rdl_edge_detect.sv
module rdl_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_n,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= int_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], int_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rdl_sequencer.sv
module rdl_sequencer
  import rdl_pkg::*;
#(
  parameter int NUM_READS = 4,
  parameter int PULSE_LOW = 2,
  parameter int PULSE_GAP = 2,
  localparam int SEL_W = $clog2(NUM_READS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] chan_sel,
  output logic             cs_n,
  output logic             rd_n,
  output logic             strobe_o,
  output logic             overrun_o
);
  localparam int CNT_MAX = (PULSE_LOW > PULSE_GAP) ? PULSE_LOW : PULSE_GAP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = $clog2(NUM_READS + 1);

  phase_t             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [SEL_W-1:0]   sel_q;
  logic               sel_load;
  logic               ovr_q, ovr_d;
  logic               low_done, gap_done;

  assign low_done = (cnt_q == CNT_W'(PULSE_LOW - 1));
  assign gap_done = (cnt_q == CNT_W'(PULSE_GAP - 1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    sel_load = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d  = PH_GAP;
          cnt_d    = '0;
          idx_d    = '0;
          sel_load = 1'b1;
        end
      end
      PH_GAP: begin
        if (gap_done) begin
          cnt_d   = '0;
          state_d = (idx_q == IDX_W'(NUM_READS)) ? PH_IDLE : PH_LOW;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_LOW: begin
        if (low_done) begin
          cnt_d   = '0;
          idx_d   = idx_q + IDX_W'(1);
          state_d = PH_GAP;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = PH_IDLE;
    endcase
    ovr_d = ovr_q | (start_i & (state_q != PH_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= chan_sel;
  end

  assign cs_n      = (state_q == PH_IDLE);
  assign rd_n      = (state_q != PH_LOW);
  assign strobe_o  = (state_q == PH_LOW) && low_done && (idx_q == IDX_W'(sel_q));
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rdl_capture.sv
module rdl_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] held_data,
  output logic              held_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_data <= '0;
    else if (strobe_i) held_data <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_valid <= 1'b0;
    else        held_valid <= strobe_i;
  end
endmodule

// File: rtl/burst_readout_latch.sv
module burst_readout_latch #(
  parameter int NUM_READS   = 4,
  parameter int PULSE_LOW   = 2,
  parameter int PULSE_GAP   = 2,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(NUM_READS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_n,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [DATA_W-1:0] data_in,
  output logic              cs_n,
  output logic              rd_n,
  output logic              latch_stb,
  output logic [DATA_W-1:0] held_data,
  output logic              held_valid,
  output logic              overrun
);
  logic fall;

  rdl_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .int_n  (int_n),
    .fall_o (fall)
  );

  rdl_sequencer #(
    .NUM_READS (NUM_READS),
    .PULSE_LOW (PULSE_LOW),
    .PULSE_GAP (PULSE_GAP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (fall),
    .chan_sel  (chan_sel),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .strobe_o  (latch_stb),
    .overrun_o (overrun)
  );

  rdl_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (latch_stb),
    .data_in    (data_in),
    .held_data  (held_data),
    .held_valid (held_valid)
  );
endmodule

// File: rtl/burst_readout_latch_chk.sv
module burst_readout_latch_chk #(
  parameter int PULSE_LOW = 2,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              latch_stb,
  input logic [DATA_W-1:0] held_data,
  input logic              held_valid,
  input logic              overrun
);
  localparam int RUN_W = $clog2(PULSE_LOW + 1) + 1;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_run <= '0;
    else if (rd_n) low_run <= '0;
    else           low_run <= low_run + RUN_W'(1);
  end

  assert_rd_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (low_run == RUN_W'(PULSE_LOW)));
  assert_stb_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> !rd_n);
  assert_stb_last_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> rd_n);
  assert_valid_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> held_valid);
  assert_valid_only_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid |-> $past(latch_stb));
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !held_valid |-> $stable(held_data));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind burst_readout_latch burst_readout_latch_chk #(
  .PULSE_LOW (PULSE_LOW),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .latch_stb  (latch_stb),
  .held_data  (held_data),
  .held_valid (held_valid),
  .overrun    (overrun)
);

// File: tb/burst_readout_latch_bench.sv
module burst_readout_latch_bench;
  localparam int PL = 2;
  localparam int PG = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        int_n;
  logic [1:0]  chan_sel;
  logic [15:0] data_in;
  logic        cs_n, rd_n, latch_stb, held_valid, overrun;
  logic [15:0] held_data;

  int n_checks = 0;
  int n_fails  = 0;

  int lat, reads, low_bad, gap_bad, cs_viol, stb_cnt, stb_idx, stb_bad;
  int valid_cnt, idle_viol;
  logic [15:0] valid_data;

  always #5 clk = ~clk;

  burst_readout_latch u_burst_readout_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_n      (int_n),
    .chan_sel   (chan_sel),
    .data_in    (data_in),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .latch_stb  (latch_stb),
    .held_data  (held_data),
    .held_valid (held_valid),
    .overrun    (overrun)
  );

  function automatic logic [15:0] pat(input logic [15:0] base, input int k);
    return base ^ (16'h1111 * 16'(k));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; int_n = 1'b1; chan_sel = 2'd0; data_in = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Runs one burst; collide drops int_n again so the edge meets read 0's strobe.
  task automatic do_burst(input logic [1:0] sel, input logic [15:0] base,
                          input bit collide, input logic [1:0] new_sel, input bit swap);
    int low_run, high_run, it;
    bit prev_rd;
    lat = 0; reads = 0; low_bad = 0; gap_bad = 0; cs_viol = 0; stb_cnt = 0;
    stb_idx = -1; stb_bad = 0; valid_cnt = 0; idle_viol = 0; valid_data = 16'h0;
    chan_sel = sel;
    int_n = 1'b1;
    repeat (4) @(negedge clk);
    int_n = 1'b0;
    do begin
      @(negedge clk);
      lat++;
    end while (cs_n && lat < 20);
    if (collide) int_n = 1'b1;
    high_run = 1; low_run = 0; prev_rd = 1'b1;
    for (it = 1; it < 100; it++) begin
      @(negedge clk);
      if (it == 1 && collide) int_n = 1'b0;
      if (it == 1 && swap) chan_sel = new_sel;
      if (!rd_n && cs_n) cs_viol++;
      if (cs_n) begin
        if (high_run != PG) gap_bad++;
        break;
      end
      if (!rd_n) begin
        if (prev_rd) begin
          if (high_run != PG) gap_bad++;
          data_in = pat(base, reads);
          reads++;
          low_run = 1; high_run = 0;
        end else low_run++;
      end else begin
        if (!prev_rd) begin
          if (low_run != PL) low_bad++;
          high_run = 1;
        end else high_run++;
      end
      prev_rd = rd_n;
      if (latch_stb) begin
        stb_cnt++;
        stb_idx = reads - 1;
        if (rd_n || low_run != PL) stb_bad++;
      end
      if (held_valid) begin
        valid_cnt++;
        valid_data = held_data;
      end
    end
    repeat (10) begin
      @(negedge clk);
      if (!cs_n) idle_viol++;
      if (!rd_n) cs_viol++;
      if (held_valid) valid_cnt++;
    end
    int_n = 1'b1;
  endtask

  task automatic check_burst(input logic [1:0] exp_sel, input logic [15:0] base);
    chk(lat == 3, "R2 start latency", lat, 3);
    chk(reads == 4, "R3 read count", reads, 4);
    chk(low_bad == 0 && gap_bad == 0, "R4 pulse/gap widths", low_bad + gap_bad, 0);
    chk(cs_viol == 0, "R5 rd outside cs", cs_viol, 0);
    chk(stb_cnt == 1 && stb_bad == 0, "R6 strobe count/position", stb_cnt, 1);
    chk(stb_idx == int'(exp_sel), "R6 strobe index", stb_idx, int'(exp_sel));
    chk(valid_cnt == 1, "R7 valid pulses", valid_cnt, 1);
    chk(valid_data == pat(base, int'(exp_sel)), "R7 held word", valid_data, pat(base, int'(exp_sel)));
    chk(held_data == pat(base, int'(exp_sel)), "R7 word kept", held_data, pat(base, int'(exp_sel)));
    chk(idle_viol == 0, "R10 no retrigger while int_n low", idle_viol, 0);
  endtask

  task automatic t_reset();
    apply_reset();
    chk(cs_n == 1'b1 && rd_n == 1'b1, "R1 strobes idle", {cs_n, rd_n}, 3);
    chk(latch_stb == 1'b0 && held_valid == 1'b0, "R1 no strobe/valid", {latch_stb, held_valid}, 0);
    chk(overrun == 1'b0, "R1 overrun clear", overrun, 0);
    chk(held_data == 16'h0, "R1 held word", held_data, 0);
  endtask

  task automatic t_each_channel();
    for (int s = 0; s < 4; s++) begin
      do_burst(2'(s), 16'h0A50 + 16'(s * 7), 1'b0, 2'd0, 1'b0);
      check_burst(2'(s), 16'h0A50 + 16'(s * 7));
      chk(overrun == 1'b0, "R9 no overrun on clean burst", overrun, 0);
    end
  endtask

  task automatic t_negative_word();
    do_burst(2'd1, 16'hF11E, 1'b0, 2'd0, 1'b0);
    check_burst(2'd1, 16'hF11E);
    chk(held_data == 16'hE00F, "R7 sign bits kept", held_data, 16'hE00F);
  endtask

  task automatic t_sel_change();
    do_burst(2'd2, 16'h3C3C, 1'b0, 2'd0, 1'b1);
    check_burst(2'd2, 16'h3C3C);
    chk(stb_idx == 2, "R8 select sampled at start", stb_idx, 2);
  endtask

  task automatic t_collide();
    do_burst(2'd0, 16'h5A01, 1'b1, 2'd0, 1'b0);
    check_burst(2'd0, 16'h5A01);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    repeat (5) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    apply_reset();
    chk(overrun == 1'b0, "R1 reset clears overrun", overrun, 0);
  endtask

  initial begin
    t_reset();
    t_each_channel();
    t_negative_word();
    t_sel_change();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule